// File: doc/BRIEF.md
# Serial Flash Programming Slave

This block lets an external programmer load an on-chip flash array over a two-wire serial link while the chip is held in its programming state. A level input (`prog_en`) selects programming mode. While it is high, the block samples a data line on each rising edge of a serial clock and groups the bits into bytes. It then decodes fixed multi-byte command sequences and turns them into one-cycle strobes on a simple flash port: write, whole-array erase, and read-back. The flash answers every strobe with a one-cycle done pulse.

After a byte is written, the block reads the same location back and compares it with the byte it sent. It drives the outcome on `miso` as a flag that stays set after a failure. The flag clears only when a later byte compares correctly. The interface has no command that reads data out. Two lock inputs come from the flash's nonvolatile configuration area. One stops writes. Together they also stop the read-back comparison. Erase is always accepted, and it is the only operation that clears the locks.

Top module: `spi_flash_prog`

## Requirements
- R1: While `prog_en` is low, serial clock edges are ignored and no flash strobe is issued. When `prog_en` falls, a partly received byte and any partly received command are discarded.
- R2: `mosi` is sampled on each rising edge of `sck`. Eight samples form one byte, with the most significant bit received first.
- R3: The byte sequence 0xAA, 0x50, H, L, D issues a single `fl_wr` with `fl_addr` = {H[5:0], L[5:0]} and `fl_wdata` = D.
- R4: The sequence 0xAA followed by 0x8A, or 0xAA followed by 0xE4, issues a single `fl_erase`.
- R5: A second byte that is not 0x50, 0x8A or 0xE4 returns the decoder to idle with no flash access. So does an address byte with bit 7 or bit 6 set. A later 0xAA starts a new command.
- R6: After each write, `fl_rd` is issued at the same address. When the read-back done arrives, `miso` becomes 1 if `fl_rdata` differs from the written byte and 0 if it matches. At all other times `miso` keeps its value.
- R7: A byte that completes while a write, read-back or erase is outstanding makes that operation fail. `miso` is set to 1, no read-back follows, and the byte is not decoded.
- R8: A failed byte does not block later commands. A later write proceeds normally and clears `miso` when it compares correctly.
- R9: With `lock_write` = 1 and `lock_verify` = 0, a write command issues no `fl_wr`, but the read-back and comparison of R6 still take place.
- R10: With `lock_write` = 1 and `lock_verify` = 1, a write command issues neither `fl_wr` nor `fl_rd`, and `miso` is unchanged.
- R11: Erase commands are carried out whatever the lock inputs are.
- R12: At most one of `fl_wr`, `fl_erase` and `fl_rd` is high in any cycle.
- R13: After `rst`, all strobes are low and `miso` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_en | input | 1 | Programming mode select, asynchronous level |
| sck | input | 1 | Serial clock, asynchronous, slower than clk/4 |
| mosi | input | 1 | Serial data in, asynchronous |
| miso | output | 1 | Sticky verify-failure flag |
| lock_write | input | 1 | Write lock from the flash configuration (1 = set) |
| lock_verify | input | 1 | Verify lock from the flash configuration (1 = set) |
| fl_addr | output | 12 | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_wr | output | 1 | One-cycle write strobe |
| fl_erase | output | 1 | One-cycle whole-array erase strobe |
| fl_rd | output | 1 | One-cycle read-back strobe |
| fl_rdata | input | 8 | Read-back data, valid with fl_done after fl_rd |
| fl_done | input | 1 | One-cycle completion pulse from the flash |

## Verification
The assertions check, on every cycle, the properties that hold without regard to the command stream:
- strobes are mutually exclusive;
- nothing is issued outside programming mode;
- a write never follows a set write lock;
- `miso` moves only on a done pulse;
- a byte is never emitted without a preceding serial clock rise.

Only the bench scenarios can show that the decoding itself is correct:
- bit order and address packing;
- both erase codes;
- aborts on bad second or address bytes;
- a byte arriving during a long flash operation spoiling it;
- the difference between the two lock levels.

Random writes over a modelled flash that can only clear bits produce a mix of passing and failing verifies, and the sticky flag is checked against a bench prediction after each write.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

    localparam int BYTE_W  = 8;
    localparam int AHI_W   = 6;
    localparam int ALO_W   = 6;
    localparam int ADDR_W  = AHI_W + ALO_W;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam int SYNC_N  = 2;

    localparam logic [BYTE_W-1:0] OP_PREFIX  = 8'hAA;
    localparam logic [BYTE_W-1:0] OP_WRITE   = 8'h50;
    localparam logic [BYTE_W-1:0] OP_ERASE_A = 8'h8A;
    localparam logic [BYTE_W-1:0] OP_ERASE_B = 8'hE4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PRE,
        S_AHI,
        S_ALO,
        S_DATA,
        S_WR_WAIT,
        S_RD_WAIT,
        S_ER_WAIT
    } seq_state_t;

    typedef struct packed {
        logic [AHI_W-1:0]  ahi;
        logic [ALO_W-1:0]  alo;
        logic [BYTE_W-1:0] data;
    } wr_cmd_t;

    function automatic logic is_erase_code(input logic [BYTE_W-1:0] b);
        return (b == OP_ERASE_A) || (b == OP_ERASE_B);
    endfunction

    function automatic logic addr_fits(input logic [BYTE_W-1:0] b, input int w);
        return (b >> w) == '0;
    endfunction

endpackage

// File: rtl/spi_prog_rx.sv
module spi_prog_rx
    import spi_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              sck,
    input  logic              mosi,
    output logic              prog_on,
    output logic              byte_v,
    output logic [BYTE_W-1:0] byte_d
);

    logic [SYNC_N-1:0] en_sr, sck_sr, mosi_sr;
    logic              sck_s, mosi_s, sck_prev, sck_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;

    assign prog_on  = en_sr[SYNC_N-1];
    assign sck_s    = sck_sr[SYNC_N-1];
    assign mosi_s   = mosi_sr[SYNC_N-1];
    assign sck_rise = prog_on && sck_s && !sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_sr    <= '0;
            sck_sr   <= '0;
            mosi_sr  <= '0;
            sck_prev <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_v   <= 1'b0;
            byte_d   <= '0;
        end else begin
            en_sr    <= {en_sr[SYNC_N-2:0], prog_en};
            sck_sr   <= {sck_sr[SYNC_N-2:0], sck};
            mosi_sr  <= {mosi_sr[SYNC_N-2:0], mosi};
            sck_prev <= sck_s;
            byte_v   <= 1'b0;
            if (!prog_on) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[BYTE_W-2:0], mosi_s};
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    bit_cnt <= '0;
                    byte_v  <= 1'b1;
                    byte_d  <= {shreg[BYTE_W-2:0], mosi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    // R2: a byte is only completed by a serial clock rise
    a_r2_byte_after_rise: assert property (@(posedge clk) disable iff (rst)
        byte_v |-> $past(sck_rise));

endmodule

// File: rtl/spi_prog_seq.sv
module spi_prog_seq
    import spi_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_on,
    input  logic              byte_v,
    input  logic [BYTE_W-1:0] byte_d,
    input  logic              lock_write,
    input  logic              lock_verify,
    input  logic              fl_done,
    input  logic [BYTE_W-1:0] fl_rdata,
    output logic              fl_wr,
    output logic              fl_erase,
    output logic              fl_rd,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BYTE_W-1:0] fl_wdata,
    output logic              verify_fail
);

    seq_state_t state;
    wr_cmd_t    cmd;
    logic       spoiled;
    logic       bad_now;

    assign fl_addr  = {cmd.ahi, cmd.alo};
    assign fl_wdata = cmd.data;
    assign bad_now  = spoiled || byte_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            cmd         <= '0;
            spoiled     <= 1'b0;
            verify_fail <= 1'b0;
            fl_wr       <= 1'b0;
            fl_erase    <= 1'b0;
            fl_rd       <= 1'b0;
        end else begin
            fl_wr    <= 1'b0;
            fl_erase <= 1'b0;
            fl_rd    <= 1'b0;
            if (!prog_on) begin
                state   <= S_IDLE;
                spoiled <= 1'b0;
            end else begin
                case (state)
                    S_IDLE: if (byte_v && byte_d == OP_PREFIX) state <= S_PRE;
                    S_PRE: if (byte_v) begin
                        if (byte_d == OP_WRITE) begin
                            state <= S_AHI;
                        end else if (is_erase_code(byte_d)) begin
                            fl_erase <= 1'b1;
                            spoiled  <= 1'b0;
                            state    <= S_ER_WAIT;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    S_AHI: if (byte_v) begin
                        if (addr_fits(byte_d, AHI_W)) begin
                            cmd.ahi <= byte_d[AHI_W-1:0];
                            state   <= S_ALO;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    S_ALO: if (byte_v) begin
                        if (addr_fits(byte_d, ALO_W)) begin
                            cmd.alo <= byte_d[ALO_W-1:0];
                            state   <= S_DATA;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    S_DATA: if (byte_v) begin
                        cmd.data <= byte_d;
                        spoiled  <= 1'b0;
                        if (!lock_write) begin
                            fl_wr <= 1'b1;
                            state <= S_WR_WAIT;
                        end else if (!lock_verify) begin
                            fl_rd <= 1'b1;
                            state <= S_RD_WAIT;
                        end else begin
                            state <= S_IDLE;
                        end
                    end
                    S_WR_WAIT: begin
                        if (byte_v) spoiled <= 1'b1;
                        if (fl_done) begin
                            if (bad_now) begin
                                verify_fail <= 1'b1;
                                state       <= S_IDLE;
                            end else begin
                                fl_rd <= 1'b1;
                                state <= S_RD_WAIT;
                            end
                        end
                    end
                    S_RD_WAIT: begin
                        if (byte_v) spoiled <= 1'b1;
                        if (fl_done) begin
                            verify_fail <= bad_now || (fl_rdata != cmd.data);
                            state       <= S_IDLE;
                        end
                    end
                    S_ER_WAIT: begin
                        if (byte_v) spoiled <= 1'b1;
                        if (fl_done) begin
                            if (bad_now) verify_fail <= 1'b1;
                            state <= S_IDLE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R12: strobes are mutually exclusive
    a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({fl_wr, fl_erase, fl_rd}));

    // R1: nothing issued once programming mode is off
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !prog_on |=> !(fl_wr || fl_erase || fl_rd));

    // R9: a write never follows a set write lock
    a_r9_no_locked_write: assert property (@(posedge clk) disable iff (rst)
        fl_wr |-> !$past(lock_write));

    // R6: the verify flag moves only on a flash completion
    a_r6_flag_on_done: assert property (@(posedge clk) disable iff (rst)
        !fl_done |=> $stable(verify_fail));

endmodule

// File: rtl/spi_flash_prog.sv
module spi_flash_prog
    import spi_prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso,
    input  logic              lock_write,
    input  logic              lock_verify,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BYTE_W-1:0] fl_wdata,
    output logic              fl_wr,
    output logic              fl_erase,
    output logic              fl_rd,
    input  logic [BYTE_W-1:0] fl_rdata,
    input  logic              fl_done
);

    logic              prog_on;
    logic              byte_v;
    logic [BYTE_W-1:0] byte_d;

    spi_prog_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .prog_en (prog_en),
        .sck     (sck),
        .mosi    (mosi),
        .prog_on (prog_on),
        .byte_v  (byte_v),
        .byte_d  (byte_d)
    );

    spi_prog_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .prog_on     (prog_on),
        .byte_v      (byte_v),
        .byte_d      (byte_d),
        .lock_write  (lock_write),
        .lock_verify (lock_verify),
        .fl_done     (fl_done),
        .fl_rdata    (fl_rdata),
        .fl_wr       (fl_wr),
        .fl_erase    (fl_erase),
        .fl_rd       (fl_rd),
        .fl_addr     (fl_addr),
        .fl_wdata    (fl_wdata),
        .verify_fail (miso)
    );

    // R13: reset leaves the flash port idle and the flag clear
    a_r13_reset_state: assert property (@(posedge clk)
        $past(rst) |-> !(fl_wr || fl_erase || fl_rd || miso));

endmodule

// File: tb/tb_spi_flash_prog.sv
`timescale 1ns/1ps
module tb_spi_flash_prog;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_en = 1'b0;
    logic        sck = 1'b0;
    logic        mosi = 1'b0;
    logic        lock_write = 1'b0;
    logic        lock_verify = 1'b0;
    logic        miso;
    logic [11:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_wr, fl_erase, fl_rd;
    logic [7:0]  fl_rdata = 8'h00;
    logic        fl_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    spi_flash_prog dut (
        .clk(clk), .rst(rst), .prog_en(prog_en), .sck(sck), .mosi(mosi),
        .miso(miso), .lock_write(lock_write), .lock_verify(lock_verify),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr),
        .fl_erase(fl_erase), .fl_rd(fl_rd), .fl_rdata(fl_rdata),
        .fl_done(fl_done)
    );

    // flash model: programming can only clear bits, erase sets all bytes
    logic [7:0]  mem [0:4095];
    int          lat = 6;
    int          busy = 0;
    logic [11:0] m_a = '0;
    logic [7:0]  m_d = '0;
    int          m_op = 0;
    int          wr_cnt = 0, er_cnt = 0, rd_cnt = 0;

    always @(posedge clk) begin
        fl_done <= 1'b0;
        if (rst) begin
            busy <= 0;
            for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
        end else if (fl_wr || fl_erase || fl_rd) begin
            busy <= lat;
            m_a  <= fl_addr;
            m_d  <= fl_wdata;
            m_op <= fl_wr ? 1 : (fl_erase ? 2 : 3);
            if (fl_wr)    wr_cnt <= wr_cnt + 1;
            if (fl_erase) er_cnt <= er_cnt + 1;
            if (fl_rd)    rd_cnt <= rd_cnt + 1;
        end else if (busy != 0) begin
            busy <= busy - 1;
            if (busy == 1) begin
                fl_done <= 1'b1;
                if (m_op == 1) mem[m_a] <= mem[m_a] & m_d;
                if (m_op == 2) for (int i = 0; i < 4096; i++) mem[i] <= 8'hFF;
                if (m_op == 3) fl_rdata <= mem[m_a];
            end
        end
    end

    logic [7:0] sh [0:4095];
    logic       exp_miso = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            mosi = b[i];
            repeat (4) @(negedge clk);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic settle();
        repeat (40 + 2 * lat) @(negedge clk);
    endtask

    // bench prediction of a write command's effect
    task automatic predict_write(input logic [11:0] a, input logic [7:0] d);
        if (!lock_write) begin
            sh[a] = sh[a] & d;
            exp_miso = (sh[a] != d);
        end else if (!lock_verify) begin
            exp_miso = (sh[a] != d);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [7:0] d);
        send_byte(8'hAA);
        send_byte(8'h50);
        send_byte({2'b00, a[11:6]});
        send_byte({2'b00, a[5:0]});
        send_byte(d);
        predict_write(a, d);
        settle();
    endtask

    task automatic do_erase(input logic [7:0] code);
        send_byte(8'hAA);
        send_byte(code);
        for (int i = 0; i < 4096; i++) sh[i] = 8'hFF;
        settle();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int w0, e0, r0;
        logic [11:0] ra;
        logic [7:0]  rd;
        void'($urandom(32'h5EED_2051));
        for (int i = 0; i < 4096; i++) sh[i] = 8'hFF;

        repeat (4) @(negedge clk);
        check("R13 strobes", {fl_wr, fl_erase, fl_rd}, 0);
        check("R13 miso", miso, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: with programming mode off, a full erase sequence is ignored
        e0 = er_cnt;
        send_byte(8'hAA);
        send_byte(8'h8A);
        settle();
        check("R1 ignored while off", er_cnt, e0);

        prog_en = 1'b1;
        repeat (10) @(negedge clk);

        // R3, R2, R6: basic write with bit order and address packing
        w0 = wr_cnt; r0 = rd_cnt;
        do_write(12'h123, 8'h5A);
        check("R3 write strobe count", wr_cnt, w0 + 1);
        check("R2/R3 data at packed address", mem[12'h123], 8'h5A);
        check("R6 readback issued", rd_cnt, r0 + 1);
        check("R6 pass clears flag", miso, 0);

        // R6 failing compare, R8 later write recovers
        do_write(12'h123, 8'hA5);
        check("R6 fail sets flag", miso, 1);
        do_write(12'hFC1, 8'h3C);
        check("R8 later write stored", mem[12'hFC1], 8'h3C);
        check("R8 flag cleared by good byte", miso, 0);
        do_write(12'h123, 8'h0F);
        check("R6 fail again", miso, 1);

        // R4 both erase codes, flag untouched by erase
        e0 = er_cnt;
        do_erase(8'hE4);
        check("R4 erase E4", er_cnt, e0 + 1);
        check("R4 array erased", mem[12'h123], 8'hFF);
        check("R6 flag held across erase", miso, 1);
        do_erase(8'h8A);
        check("R4 erase 8A", er_cnt, e0 + 2);

        // R5: bad second byte aborts; a stray write body is not decoded
        w0 = wr_cnt; e0 = er_cnt;
        send_byte(8'hAA); send_byte(8'h33);
        send_byte(8'h50); send_byte(8'h00); send_byte(8'h01); send_byte(8'h00);
        settle();
        check("R5 bad opcode no write", wr_cnt, w0);
        send_byte(8'hAA); send_byte(8'h50); send_byte(8'h40);
        send_byte(8'h01); send_byte(8'h00);
        settle();
        check("R5 bad address byte no write", wr_cnt, w0);
        check("R5 memory untouched", mem[12'h001], 8'hFF);
        do_erase(8'h8A);
        check("R5 restart after abort", er_cnt, e0 + 1);

        // R1: prog_en fall discards partial byte and partial command
        e0 = er_cnt;
        send_bits(8'hF0, 4);
        prog_en = 1'b0; repeat (10) @(negedge clk);
        prog_en = 1'b1; repeat (10) @(negedge clk);
        do_erase(8'h8A);
        check("R1 partial byte dropped", er_cnt, e0 + 1);
        send_byte(8'hAA);
        prog_en = 1'b0; repeat (10) @(negedge clk);
        prog_en = 1'b1; repeat (10) @(negedge clk);
        send_byte(8'h8A);
        settle();
        check("R1 partial command dropped", er_cnt, e0 + 1);

        // R7: byte arriving during a slow write spoils it
        do_write(12'h020, 8'hFF);
        check("R7 setup flag clear", miso, 0);
        lat = 200;
        r0 = rd_cnt;
        send_byte(8'hAA); send_byte(8'h50); send_byte(8'h00);
        send_byte(8'h10); send_byte(8'h11);
        send_byte(8'h00);
        sh[12'h010] = 8'h11;
        exp_miso = 1'b1;
        settle();
        check("R7 flag set", miso, 1);
        check("R7 no readback", rd_cnt, r0);
        lat = 6;
        do_write(12'h011, 8'h22);
        check("R7/R8 recovered", miso, 0);

        // R9: write lock keeps readback compare
        lock_write = 1'b1;
        w0 = wr_cnt; r0 = rd_cnt;
        do_write(12'h050, 8'hFF);
        check("R9 no write", wr_cnt, w0);
        check("R9 compare pass", miso, 0);
        do_write(12'h050, 8'h00);
        check("R9 readback issued", rd_cnt, r0 + 2);
        check("R9 compare fail", miso, 1);
        check("R9 memory unchanged", mem[12'h050], 8'hFF);

        // R10: both locks: nothing issued, flag held
        lock_verify = 1'b1;
        w0 = wr_cnt; r0 = rd_cnt;
        do_write(12'h050, 8'hFF);
        check("R10 no write", wr_cnt, w0);
        check("R10 no read", rd_cnt, r0);
        check("R10 flag held", miso, 1);

        // R11: erase under full lock
        e0 = er_cnt;
        do_erase(8'hE4);
        check("R11 erase under lock", er_cnt, e0 + 1);
        lock_write = 1'b0; lock_verify = 1'b0;

        // random writes with occasional erases
        for (int k = 0; k < 60; k++) begin
            if ($urandom_range(7) == 0) begin
                do_erase(($urandom_range(1) == 0) ? 8'h8A : 8'hE4);
            end else begin
                ra = 12'($urandom_range(63));
                rd = 8'($urandom);
                do_write(ra, rd);
                check("R3 random data", mem[ra], sh[ra]);
                check("R6 random flag", miso, exp_miso);
            end
        end
        check("R12 idle after run", {fl_wr, fl_erase, fl_rd}, 0);

        finish_run();
    end

endmodule